// File: doc/BRIEF.md
# PS/2 host link controller

This block is the host side of a single PS/2 keyboard or mouse port. It watches the open-drain clock and data lines through a synchronizer and glitch filter. It assembles device-to-host frames into bytes and hands each byte downstream on a strobe/acknowledge handshake. Each byte carries four qualifiers: parity error, bad start bit, bad stop bit and lost byte.

In the other direction it takes a byte on a strobe/acknowledge handshake and runs the host-to-device request-to-send sequence. It holds the clock low for a set time, then takes the data line low and releases the clock. From then on it follows the clock edges the device generates. The clock line can be held low on request, or held low automatically while a received byte waits for acknowledgement. Lost clocking in either direction and a missing acknowledge bit are reported as sticky error levels.

Each pin is modelled as an active-low drive enable. A line is either pulled to 0 or released; a pull-up is assumed outside the block.

Top module: `ps2_host_link`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, both drive enables are high (lines released), `rx_stb` is 0, `tx_ack` is 0 and all three error outputs are 0.
- R2: A device frame is 11 bits, each sampled on a falling edge of the filtered clock: a start bit, eight data bits LSB first, a parity bit and a stop bit. The byte appears on `rx_byte` with `rx_stb` high. Strobe and byte stay unchanged until a cycle in which `rx_ack` is high, and the strobe drops after that cycle.
- R3: Parity is odd over the eight data bits plus the parity bit. `rx_err_parity` is 1 when that count of ones is even.
- R4: `rx_err_start` is 1 when the first bit of the frame was 1. `rx_err_stop` is 1 when the last bit was 0.
- R5: A frame that completes while the previous byte is still unacknowledged is dropped, and the held byte is kept. The next byte delivered carries `rx_err_lost` = 1, and later bytes carry 0.
- R6: While `inhibit_req` is 1 and no transmission is in progress, the clock line is pulled low and the data line is released.
- R7: With `auto_inhibit_en` = 1, the clock line is pulled low while `rx_stb` is high and not yet acknowledged. With `auto_inhibit_en` = 0, a pending byte does not pull the clock.
- R8: If the clock has no falling edge for `TIMEOUT_CYCLES` cycles partway through a device frame, `err_rx_timeout` becomes 1. The partial frame is discarded, and the next full frame is received correctly.
- R9: Acceptance of a transmit byte is shown by `tx_ack` high for exactly one cycle. The clock is then pulled low for exactly `HOLD_CYCLES` cycles with data released. Next, data is pulled low and the clock released. Each device falling edge then puts out the next bit: eight data bits LSB first, the odd parity bit, and a released stop bit.
- R10: If the data line is high at the eleventh device falling edge of a transmission, `err_nack` becomes 1.
- R11: If the device stops producing falling edges for `TIMEOUT_CYCLES` cycles during a transmission, `err_tx_timeout` becomes 1 and both lines are released.
- R12: Each error output stays at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_stb | input | 1 | Transmit byte offered |
| tx_byte | input | 8 | Byte to send to the device |
| tx_ack | output | 1 | Transmit byte taken this cycle |
| rx_stb | output | 1 | Received byte pending |
| rx_byte | output | 8 | Received byte |
| rx_ack | input | 1 | Downstream takes the pending byte |
| rx_err_parity | output | 1 | Parity qualifier of the pending byte |
| rx_err_start | output | 1 | Start-bit qualifier of the pending byte |
| rx_err_stop | output | 1 | Stop-bit qualifier of the pending byte |
| rx_err_lost | output | 1 | A frame was dropped before this byte |
| inhibit_req | input | 1 | Hold the device off |
| auto_inhibit_en | input | 1 | Hold the device off while a byte is pending |
| err_nack | output | 1 | Device did not acknowledge a sent byte (sticky) |
| err_tx_timeout | output | 1 | Clocking stopped during transmission (sticky) |
| err_rx_timeout | output | 1 | Clocking stopped during reception (sticky) |
| line_clk_in | input | 1 | Sensed level of the clock line |
| line_dat_in | input | 1 | Sensed level of the data line |
| line_clk_drive_n | output | 1 | 0 pulls the clock line low |
| line_dat_drive_n | output | 1 | 0 pulls the data line low |

## Verification
Reception is swept over all 256 byte values with well-formed frames. The byte and all four qualifiers must come out exactly, so any bit-order or shift-count fault shows up. A second pass corrupts parity, start and stop bits one at a time, which tells the three qualifiers apart from one another. Transmission is run with a modelled device over a run of byte values. The host's clock-hold length and every bit it puts out are captured and compared with arithmetic expectations, including the parity bit. Separate scenarios cover back-to-back frames with no acknowledgement, a missing device acknowledge, clocks that stop mid-frame in each direction, and manual and automatic inhibit. These show the drop-newest rule, the timeout paths and the hold-off conditions.

// File: rtl/ps2_host_link_pkg.sv
// Shared definitions for the PS/2 host link: frame length, transmit
// sequencer states, received-byte qualifiers and the parity helper.
package ps2_host_link_pkg;

    // start + 8 data + parity + stop
    localparam int FRAME_BITS = 11;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_HOLD,
        TX_SHIFT,
        TX_ACK,
        TX_DONE
    } tx_state_e;

    typedef struct packed {
        logic parity;
        logic start;
        logic stop;
        logic lost;
    } rx_flags_t;

    // Parity bit that makes the count of ones over data plus parity odd
    function automatic logic odd_parity_bit(input logic [7:0] d);
        return ~(^d);
    endfunction

endpackage

// File: rtl/ps2_line_filter.sv
// Brings one asynchronous PS/2 line into the clock domain and removes
// short glitches.
// Assumes: the line idles high; a change is accepted only after it has
// been seen on FILTER_LEN consecutive synchronized samples.
module ps2_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILTER_LEN  = 3,
    localparam int CNT_W = $clog2(FILTER_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       agree_cnt;

    // Synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end

    // Accept a new level only after it is stable for FILTER_LEN samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level     <= 1'b1;
            agree_cnt <= '0;
        end else if (sync_q[SYNC_STAGES-1] == level) begin
            agree_cnt <= '0;
        end else if (agree_cnt == CNT_W'(FILTER_LEN - 1)) begin
            level     <= sync_q[SYNC_STAGES-1];
            agree_cnt <= '0;
        end else begin
            agree_cnt <= agree_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ps2_rx_deframer.sv
// Assembles device-to-host frames bit by bit on filtered clock falls,
// presents each byte with its qualifiers on a strobe/acknowledge
// handshake, drops frames that arrive while a byte is pending, and
// abandons a frame whose clocking stops.
// Assumes: hold is high whenever the host owns or pulls the clock line.
module ps2_rx_deframer
    import ps2_host_link_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 4096,
    localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1),
    localparam int BIT_W = $clog2(FRAME_BITS + 1)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold,
    input  logic      bit_fall,
    input  logic      bit_val,
    input  logic      ack,
    output logic      stb,
    output logic [7:0] data,
    output rx_flags_t flags,
    output logic      busy,
    output logic      err_timeout
);

    logic [FRAME_BITS-2:0] shreg;
    logic [BIT_W-1:0]      bit_cnt;
    logic [TMO_W-1:0]      tmo_cnt;
    logic                  lost_pend;

    assign busy = (bit_cnt != '0);

    // Bit collection, byte hand-off, overrun tracking and timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg       <= '0;
            bit_cnt     <= '0;
            tmo_cnt     <= '0;
            lost_pend   <= 1'b0;
            stb         <= 1'b0;
            data        <= '0;
            flags       <= '0;
            err_timeout <= 1'b0;
        end else begin
            if (stb && ack) stb <= 1'b0;
            if (hold) begin
                bit_cnt <= '0;
                tmo_cnt <= '0;
            end else if (bit_fall) begin
                tmo_cnt <= '0;
                if (bit_cnt == BIT_W'(FRAME_BITS - 1)) begin
                    bit_cnt <= '0;
                    if (stb && !ack) begin
                        lost_pend <= 1'b1;
                    end else begin
                        stb          <= 1'b1;
                        data         <= shreg[8:1];
                        flags.parity <= ~(^shreg[9:1]);
                        flags.start  <= shreg[0];
                        flags.stop   <= ~bit_val;
                        flags.lost   <= lost_pend;
                        lost_pend    <= 1'b0;
                    end
                end else begin
                    shreg   <= {bit_val, shreg[FRAME_BITS-2:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (bit_cnt != '0) begin
                if (tmo_cnt == TMO_W'(TIMEOUT_CYCLES - 1)) begin
                    bit_cnt     <= '0;
                    tmo_cnt     <= '0;
                    err_timeout <= 1'b1;
                end else begin
                    tmo_cnt <= tmo_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ps2_tx_sequencer.sv
// Runs the host-to-device sequence: clock hold, start bit, data, parity
// and stop bits on device clock falls, then the acknowledge sample.
// Assumes: start_ok is low while a device frame is partly received.
module ps2_tx_sequencer
    import ps2_host_link_pkg::*;
#(
    parameter int HOLD_CYCLES    = 25000,
    parameter int TIMEOUT_CYCLES = 4096,
    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1),
    localparam int TMO_W  = $clog2(TIMEOUT_CYCLES + 1),
    localparam int BIT_W  = $clog2(FRAME_BITS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [7:0] byte_in,
    input  logic       start_ok,
    input  logic       clk_fall,
    input  logic       clk_lvl,
    input  logic       dat_lvl,
    output logic       accept,
    output logic       idle,
    output logic       drive_clk_low,
    output logic       drive_dat_low,
    output logic       err_nack,
    output logic       err_timeout
);

    tx_state_e             state;
    logic [HOLD_W-1:0]     hold_cnt;
    logic [TMO_W-1:0]      tmo_cnt;
    logic [BIT_W-1:0]      bit_cnt;
    logic [FRAME_BITS-1:0] shreg;

    assign idle          = (state == TX_IDLE);
    assign accept        = idle && req && start_ok;
    assign drive_clk_low = (state == TX_HOLD);
    assign drive_dat_low = (state == TX_SHIFT) && !shreg[0];

    // Sequence state, bit shifting, acknowledge sampling and timeout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= TX_IDLE;
            hold_cnt    <= '0;
            tmo_cnt     <= '0;
            bit_cnt     <= '0;
            shreg       <= '1;
            err_nack    <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            case (state)
                TX_IDLE: begin
                    if (accept) begin
                        state    <= TX_HOLD;
                        hold_cnt <= '0;
                        shreg    <= {1'b1, odd_parity_bit(byte_in), byte_in, 1'b0};
                    end
                end
                TX_HOLD: begin
                    if (hold_cnt == HOLD_W'(HOLD_CYCLES - 1)) begin
                        state   <= TX_SHIFT;
                        tmo_cnt <= '0;
                        bit_cnt <= '0;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                default: begin
                    if (state == TX_DONE && clk_lvl) begin
                        state <= TX_IDLE;
                    end else if (clk_fall) begin
                        tmo_cnt <= '0;
                        if (state == TX_SHIFT) begin
                            shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                            if (bit_cnt == BIT_W'(FRAME_BITS - 2)) state <= TX_ACK;
                            else bit_cnt <= bit_cnt + 1'b1;
                        end else if (state == TX_ACK) begin
                            if (dat_lvl) err_nack <= 1'b1;
                            state <= TX_DONE;
                        end
                    end else if (tmo_cnt == TMO_W'(TIMEOUT_CYCLES - 1)) begin
                        state       <= TX_IDLE;
                        shreg       <= '1;
                        err_timeout <= 1'b1;
                    end else begin
                        tmo_cnt <= tmo_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/ps2_host_link.sv
// PS/2 host link top: filters both lines, detects clock falls, and joins
// the receive deframer and transmit sequencer. Also decides who pulls
// the clock line: the transmit hold phase, or an inhibit (manual, or
// automatic while a received byte waits).
// Assumes: external pull-ups; the pins are driven only to 0 or released.
module ps2_host_link #(
    parameter int HOLD_CYCLES    = 25000,
    parameter int TIMEOUT_CYCLES = 500000,
    parameter int FILTER_LEN     = 3,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_stb,
    input  logic [7:0] tx_byte,
    output logic       tx_ack,
    output logic       rx_stb,
    output logic [7:0] rx_byte,
    input  logic       rx_ack,
    output logic       rx_err_parity,
    output logic       rx_err_start,
    output logic       rx_err_stop,
    output logic       rx_err_lost,
    input  logic       inhibit_req,
    input  logic       auto_inhibit_en,
    output logic       err_nack,
    output logic       err_tx_timeout,
    output logic       err_rx_timeout,
    input  logic       line_clk_in,
    input  logic       line_dat_in,
    output logic       line_clk_drive_n,
    output logic       line_dat_drive_n
);
    import ps2_host_link_pkg::*;

    localparam int LINES = 2;  // index 0 = clock, 1 = data

    logic [LINES-1:0] line_raw;
    logic [LINES-1:0] line_filt;
    logic             clk_prev;
    logic             clk_fall;
    logic             tx_idle;
    logic             tx_clk_low;
    logic             tx_dat_low;
    logic             rx_busy;
    logic             hold_off;
    logic             clk_pull;
    rx_flags_t        rx_flags;

    assign line_raw = {line_dat_in, line_clk_in};

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            ps2_line_filter #(
                .SYNC_STAGES (SYNC_STAGES),
                .FILTER_LEN  (FILTER_LEN)
            ) u_filt (
                .clk   (clk),
                .rst_n (rst_n),
                .raw   (line_raw[g]),
                .level (line_filt[g])
            );
        end
    endgenerate

    // Previous filtered clock level for fall detection
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b1;
        else        clk_prev <= line_filt[0];
    end

    assign clk_fall = clk_prev && !line_filt[0];

    assign hold_off = inhibit_req || (auto_inhibit_en && rx_stb);
    assign clk_pull = tx_clk_low || (tx_idle && hold_off);

    assign line_clk_drive_n = ~clk_pull;
    assign line_dat_drive_n = ~tx_dat_low;

    ps2_rx_deframer #(
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (clk_pull || !tx_idle),
        .bit_fall    (clk_fall),
        .bit_val     (line_filt[1]),
        .ack         (rx_ack),
        .stb         (rx_stb),
        .data        (rx_byte),
        .flags       (rx_flags),
        .busy        (rx_busy),
        .err_timeout (err_rx_timeout)
    );

    ps2_tx_sequencer #(
        .HOLD_CYCLES    (HOLD_CYCLES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (tx_stb),
        .byte_in       (tx_byte),
        .start_ok      (!rx_busy),
        .clk_fall      (clk_fall),
        .clk_lvl       (line_filt[0]),
        .dat_lvl       (line_filt[1]),
        .accept        (tx_ack),
        .idle          (tx_idle),
        .drive_clk_low (tx_clk_low),
        .drive_dat_low (tx_dat_low),
        .err_nack      (err_nack),
        .err_timeout   (err_tx_timeout)
    );

    assign rx_err_parity = rx_flags.parity;
    assign rx_err_start  = rx_flags.start;
    assign rx_err_stop   = rx_flags.stop;
    assign rx_err_lost   = rx_flags.lost;

endmodule

// File: rtl/ps2_host_link_chk.sv
// Temporal checks on the PS/2 host link, bound into the top module.
module ps2_host_link_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_stb,
    input logic       tx_ack,
    input logic       rx_stb,
    input logic       rx_ack,
    input logic [7:0] rx_byte,
    input logic       inhibit_req,
    input logic       auto_inhibit_en,
    input logic       err_nack,
    input logic       err_tx_timeout,
    input logic       err_rx_timeout,
    input logic       line_clk_drive_n,
    input logic       line_dat_drive_n,
    input logic       tx_idle
);

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) && !inhibit_req |-> line_clk_drive_n && line_dat_drive_n && !rx_stb);

    // R2
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb && !rx_ack |=> rx_stb && $stable(rx_byte));

    // R6
    inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_req && tx_idle |-> !line_clk_drive_n && line_dat_drive_n);

    // R7
    auto_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_inhibit_en && rx_stb && tx_idle |-> !line_clk_drive_n);

    // R9
    clk_hold_dat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_clk_drive_n |-> line_dat_drive_n);

    // R9
    tx_ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> tx_stb ##1 !tx_ack);

    // R11
    tx_timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_tx_timeout) |-> line_dat_drive_n && tx_idle);

    // R12
    nack_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_nack |=> err_nack);

    // R12
    tx_timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_tx_timeout |=> err_tx_timeout);

    // R12
    rx_timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_rx_timeout |=> err_rx_timeout);

endmodule

bind ps2_host_link ps2_host_link_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .tx_stb           (tx_stb),
    .tx_ack           (tx_ack),
    .rx_stb           (rx_stb),
    .rx_ack           (rx_ack),
    .rx_byte          (rx_byte),
    .inhibit_req      (inhibit_req),
    .auto_inhibit_en  (auto_inhibit_en),
    .err_nack         (err_nack),
    .err_tx_timeout   (err_tx_timeout),
    .err_rx_timeout   (err_rx_timeout),
    .line_clk_drive_n (line_clk_drive_n),
    .line_dat_drive_n (line_dat_drive_n),
    .tx_idle          (tx_idle)
);

// File: tb/ps2_host_link_bench.sv
`timescale 1ns/1ps
// Self-checking bench: models a PS/2 device on wired-AND lines.
module ps2_host_link_bench;

    localparam int HOLD    = 60;
    localparam int TMO     = 100;
    localparam int HALF    = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_stb = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_ack;
    logic       rx_stb;
    logic [7:0] rx_byte;
    logic       rx_ack = 1'b0;
    logic       rx_err_parity, rx_err_start, rx_err_stop, rx_err_lost;
    logic       inhibit_req = 1'b0;
    logic       auto_inhibit_en = 1'b0;
    logic       err_nack, err_tx_timeout, err_rx_timeout;
    logic       line_clk_drive_n, line_dat_drive_n;
    logic       dev_clk = 1'b1;
    logic       dev_dat = 1'b1;
    logic       ln_clk, ln_dat;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    assign ln_clk = dev_clk & line_clk_drive_n;
    assign ln_dat = dev_dat & line_dat_drive_n;

    always #2 clk = ~clk;

    ps2_host_link #(
        .HOLD_CYCLES    (HOLD),
        .TIMEOUT_CYCLES (TMO),
        .FILTER_LEN     (3),
        .SYNC_STAGES    (2)
    ) u_ps2_host_link (
        .clk (clk), .rst_n (rst_n),
        .tx_stb (tx_stb), .tx_byte (tx_byte), .tx_ack (tx_ack),
        .rx_stb (rx_stb), .rx_byte (rx_byte), .rx_ack (rx_ack),
        .rx_err_parity (rx_err_parity), .rx_err_start (rx_err_start),
        .rx_err_stop (rx_err_stop), .rx_err_lost (rx_err_lost),
        .inhibit_req (inhibit_req), .auto_inhibit_en (auto_inhibit_en),
        .err_nack (err_nack), .err_tx_timeout (err_tx_timeout),
        .err_rx_timeout (err_rx_timeout),
        .line_clk_in (ln_clk), .line_dat_in (ln_dat),
        .line_clk_drive_n (line_clk_drive_n), .line_dat_drive_n (line_dat_drive_n)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(1);
    endtask

    // Frame as sent by the device: {stop, parity, data, start}
    function automatic logic [10:0] mk_frame(input logic [7:0] d, input bit bad_par,
                                             input bit bad_start, input bit bad_stop);
        return {~bad_stop, (~(^d)) ^ bad_par, d, bad_start};
    endfunction

    // Device sends the first nbits of a frame
    task automatic dev_send(input logic [10:0] fr, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            dev_dat = fr[i];
            tick(HALF);
            dev_clk = 1'b0;
            tick(HALF);
            dev_clk = 1'b1;
        end
        dev_dat = 1'b1;
        tick(HALF);
    endtask

    // Host transmits d; device clocks stop_at falls (11 = full) and acks if ack_en
    task automatic host_send(input logic [7:0] d, input bit ack_en, input int stop_at,
                             output logic [9:0] got, output int hold_len, output int acks);
        got = '1;
        hold_len = 0;
        acks = 0;
        tx_byte = d;
        tx_stb = 1'b1;
        do begin
            @(negedge clk);
        end while (!tx_ack);
        acks = 1;
        @(posedge clk);
        #1 tx_stb = 1'b0;
        forever begin
            @(negedge clk);
            if (tx_ack) acks++;
            if (!line_clk_drive_n) hold_len++;
            else if (!ln_dat) break;
        end
        for (int k = 1; k <= 10; k++) begin
            if (k > stop_at) break;
            tick(HALF);
            dev_clk = 1'b0;
            tick(HALF);
            got[k-1] = ln_dat;
            dev_clk = 1'b1;
        end
        if (stop_at >= 11) begin
            dev_dat = ack_en ? 1'b0 : 1'b1;
            tick(HALF);
            dev_clk = 1'b0;
            tick(HALF);
            dev_clk = 1'b1;
            tick(HALF);
            dev_dat = 1'b1;
            tick(8);
        end else begin
            tick(TMO + 20);
        end
    endtask

    task automatic ack_rx();
        rx_ack = 1'b1;
        tick(1);
        rx_ack = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] got;
        int hold_len;
        int acks;

        // R1: state during and right after reset
        tick(2);
        chk("R1 clk released in reset", line_clk_drive_n, 1);
        do_reset();
        chk("R1 lines released", {line_clk_drive_n, line_dat_drive_n}, 2'b11);
        chk("R1 no strobes", {rx_stb, tx_ack}, 2'b00);
        chk("R1 errors clear", {err_nack, err_tx_timeout, err_rx_timeout}, 3'b000);
        tick(4);

        // R2 R3 R4: every byte value in a clean frame
        for (int d = 0; d < 256; d++) begin
            dev_send(mk_frame(8'(d), 0, 0, 0), 11);
            chk("R2 byte strobe", {rx_stb, rx_byte}, {1'b1, 8'(d)});
            chk("R3 R4 R5 clean qualifiers",
                {rx_err_parity, rx_err_start, rx_err_stop, rx_err_lost}, 4'b0000);
            if (d == 0) begin
                tick(5);
                chk("R2 held without ack", {rx_stb, rx_byte}, 9'h100);
                chk("R7 no hold-off when disabled", line_clk_drive_n, 1);
            end
            ack_rx();
            chk("R2 strobe drops after ack", rx_stb, 0);
        end

        // R3: parity corruption on a set of bytes
        for (int d = 0; d < 16; d++) begin
            dev_send(mk_frame(8'(d * 17), 1, 0, 0), 11);
            chk("R3 parity error flagged",
                {rx_stb, rx_err_parity, rx_err_start, rx_err_stop, rx_byte},
                {4'b1100, 8'(d * 17)});
            ack_rx();
        end

        // R4: start and stop bit corruption
        for (int d = 0; d < 8; d++) begin
            dev_send(mk_frame(8'(d * 33 + 1), 0, 1, 0), 11);
            chk("R4 start error flagged",
                {rx_err_parity, rx_err_start, rx_err_stop, rx_byte}, {3'b010, 8'(d * 33 + 1)});
            ack_rx();
            dev_send(mk_frame(8'(d * 29 + 2), 0, 0, 1), 11);
            chk("R4 stop error flagged",
                {rx_err_parity, rx_err_start, rx_err_stop, rx_byte}, {3'b001, 8'(d * 29 + 2)});
            ack_rx();
        end

        // R5: frame while byte pending is dropped, next byte marked lost
        dev_send(mk_frame(8'hA1, 0, 0, 0), 11);
        dev_send(mk_frame(8'hB2, 0, 0, 0), 11);
        chk("R5 held byte kept", {rx_stb, rx_byte, rx_err_lost}, {1'b1, 8'hA1, 1'b0});
        ack_rx();
        dev_send(mk_frame(8'hC3, 0, 0, 0), 11);
        chk("R5 next byte marked lost", {rx_stb, rx_byte, rx_err_lost}, {1'b1, 8'hC3, 1'b1});
        ack_rx();
        dev_send(mk_frame(8'hD4, 0, 0, 0), 11);
        chk("R5 lost mark clears", {rx_byte, rx_err_lost}, {8'hD4, 1'b0});
        ack_rx();

        // R7: automatic hold-off while a byte waits
        auto_inhibit_en = 1'b1;
        tick(2);
        chk("R7 no hold-off when empty", line_clk_drive_n, 1);
        dev_send(mk_frame(8'h5E, 0, 0, 0), 11);
        chk("R7 clock pulled while pending", {rx_stb, line_clk_drive_n}, 2'b10);
        ack_rx();
        chk("R7 clock released after ack", line_clk_drive_n, 1);
        auto_inhibit_en = 1'b0;
        tick(HALF);

        // R6: manual inhibit
        inhibit_req = 1'b1;
        tick(1);
        chk("R6 clock pulled data released", {line_clk_drive_n, line_dat_drive_n}, 2'b01);
        tick(40);
        chk("R6 still pulled", line_clk_drive_n, 0);
        inhibit_req = 1'b0;
        tick(1);
        chk("R6 released", line_clk_drive_n, 1);
        tick(HALF);
        chk("R6 no spurious byte", rx_stb, 0);

        // R8: clocking stops mid-frame
        dev_send(mk_frame(8'h5A, 0, 0, 0), 4);
        tick(TMO + 20);
        chk("R8 rx timeout flagged", {err_rx_timeout, rx_stb}, 2'b10);
        dev_send(mk_frame(8'h3C, 0, 0, 0), 11);
        chk("R8 next frame clean", {rx_stb, rx_byte, rx_err_start, rx_err_parity}, {1'b1, 8'h3C, 2'b00});
        ack_rx();
        chk("R12 rx timeout sticky", err_rx_timeout, 1);

        // R9: transmit sweep
        do_reset();
        tick(4);
        for (int d = 0; d < 40; d++) begin
            logic [7:0] b;
            b = (d < 32) ? 8'(d) : 8'(d * 37 + 5);
            host_send(b, 1, 11, got, hold_len, acks);
            chk("R9 clock hold length", 32'(hold_len), HOLD);
            chk("R9 single ack pulse", 32'(acks), 1);
            chk("R9 bits on line", {22'd0, got}, {22'd0, 1'b1, ~(^b), b});
            chk("R10 acked byte no nack", err_nack, 0);
        end

        // R10: missing acknowledge
        host_send(8'h96, 0, 11, got, hold_len, acks);
        chk("R10 nack flagged", err_nack, 1);
        tick(20);
        chk("R12 nack sticky", err_nack, 1);

        // R11: device stops clocking mid-transmit
        do_reset();
        chk("R1 reset clears nack", err_nack, 0);
        tick(4);
        host_send(8'h0F, 1, 3, got, hold_len, acks);
        chk("R11 tx timeout flagged", err_tx_timeout, 1);
        chk("R11 lines released", {line_clk_drive_n, line_dat_drive_n}, 2'b11);
        chk("R12 tx timeout sticky", {err_tx_timeout, err_rx_timeout}, 2'b10);
        host_send(8'h71, 1, 11, got, hold_len, acks);
        chk("R11 later transmit works", {22'd0, got}, {22'd0, 1'b1, ~(^8'h71), 8'h71});

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule